// File: doc/BRIEF.md
# Systolic Reachability Mesh

This block takes the adjacency matrix of a directed graph on N vertices and returns its reflexive transitive closure: bit (i,j) of the result is 1 when vertex j can be reached from vertex i by a path of zero or more edges. The work is done on an N×N torus of one-bit cells. Each cell holds an accumulator and one slot of each of two moving copies of the matrix. One copy moves one cell right per cycle and the other moves one cell down per cycle. Both wrap around at the edges. The copies are placed on the torus at load time with a diagonal skew, so that row element (i,k) and column element (k,j) sit in cell (i,j) during the same cycle. On each cycle every cell ORs the AND of its two moving bits into its accumulator.

When a moving element reaches its own home cell, it leaves that cell carrying the cell's freshly updated accumulator in place of its old value. Later cells therefore see partial closures rather than raw edges. A pass is N cycles, and enough passes are run to cover every path of up to N-1 edges.

The caller presents the matrix on a flat input and pulses start. After a fixed number of cycles the result is streamed out one bit per cycle in row-major order, and a done flag marks the final bit.

Top module: `reach_mesh`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, res_valid and done are all 0.
- R2: The streamed result equals the reflexive transitive closure of adj_in as captured at the accepted start. Bit i*N+j of adj_in means an edge from vertex i to vertex j. The k-th streamed bit, counting from 0, is entry (k/N, k%N).
- R3: Every diagonal entry of the result is 1 whatever the input, so an empty graph yields the identity matrix.
- R4: A start pulse while busy is high is ignored. Neither the result nor its timing changes, even if adj_in changes at the same time.
- R5: res_valid first rises exactly P*N clock edges after the edge that accepted start. P is 1 when N is 2, and otherwise 2*ceil(log2(N-1))-1.
- R6: res_valid stays high for exactly N*N consecutive cycles. done is high in exactly one of them, the one carrying the last bit.
- R7: busy is high from the cycle after start is accepted up to and including the cycle of the last result bit, and low in the cycle after it.
- R8: During the compute passes no accumulator bit ever falls from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled only while idle |
| adj_in | input | N*N | Adjacency matrix, row-major, captured at start |
| busy | output | 1 | A run is in progress |
| res_valid | output | 1 | res_bit carries a result bit this cycle |
| res_bit | output | 1 | Current closure bit, row-major order |
| done | output | 1 | Marks the last result bit |

## Verification
The two events that can land in the same cycle are a new start request and an active run, either while the mesh is computing or while it is streaming out the result. The bench raises start with a different matrix three cycles into compute and again during unload. A run is judged correct if its result still matches the closure of the first matrix, the unload begins at the nominal cycle, and the mesh goes idle directly after done. A second overlap is the case where a row-home and a column-home replacement happen in the same cell at once. Every run covers it on the diagonal, and a long single cycle, which needs the longest paths, checks it through the final result.

// File: rtl/reach_pkg.sv
package reach_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DUMP = 2'd2
    } reach_phase_e;

    // Compute passes needed so that paths of up to n-1 edges are covered.
    function automatic int pass_count(input int n);
        int m;
        m = $clog2(n - 1);
        return (m == 0) ? 1 : 2 * m - 1;
    endfunction

endpackage

// File: rtl/reach_cell.sv
module reach_cell (
    input  logic acc_q,
    input  logic h_in,
    input  logic v_in,
    input  logic row_home,
    input  logic col_home,
    output logic acc_d,
    output logic h_out,
    output logic v_out
);
    always_comb begin
        acc_d = acc_q | (h_in & v_in);
        h_out = row_home ? acc_d : h_in;
        v_out = col_home ? acc_d : v_in;
    end
endmodule

// File: rtl/reach_seq.sv
module reach_seq
    import reach_pkg::*;
#(
    parameter int N      = 6,
    parameter int PASSES = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    output logic                         load_en,
    output logic                         run_en,
    output logic [$clog2(N)-1:0]         step,
    output logic [$clog2(N*N)-1:0]       dump_idx,
    output logic                         res_valid,
    output logic                         done,
    output logic                         busy
);
    localparam int NN = N * N;
    localparam int SW = $clog2(N);
    localparam int PW = $clog2(PASSES) + 1;
    localparam int IW = $clog2(NN);
    localparam logic [SW-1:0] STEP_LAST = SW'(N - 1);
    localparam logic [PW-1:0] PASS_LAST = PW'(PASSES - 1);
    localparam logic [IW-1:0] IDX_LAST  = IW'(NN - 1);

    typedef struct packed {
        reach_phase_e    phase;
        logic [SW-1:0]   step;
        logic [PW-1:0]   pass;
        logic [IW-1:0]   idx;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        load_en = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    load_en    = 1'b1;
                    s_d.phase  = PH_RUN;
                    s_d.step   = '0;
                    s_d.pass   = '0;
                end
            end
            PH_RUN: begin
                if (s_q.step == STEP_LAST) begin
                    s_d.step = '0;
                    if (s_q.pass == PASS_LAST) begin
                        s_d.phase = PH_DUMP;
                        s_d.idx   = '0;
                    end else begin
                        s_d.pass = s_q.pass + 1'b1;
                    end
                end else begin
                    s_d.step = s_q.step + 1'b1;
                end
            end
            PH_DUMP: begin
                if (s_q.idx == IDX_LAST) begin
                    s_d.phase = PH_IDLE;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, step: '0, pass: '0, idx: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign run_en    = (s_q.phase == PH_RUN);
    assign step      = s_q.step;
    assign dump_idx  = s_q.idx;
    assign res_valid = (s_q.phase == PH_DUMP);
    assign done      = (s_q.phase == PH_DUMP) && (s_q.idx == IDX_LAST);
    assign busy      = (s_q.phase != PH_IDLE);
endmodule

// File: rtl/reach_mesh.sv
module reach_mesh
    import reach_pkg::*;
#(
    parameter int N = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N*N-1:0] adj_in,
    output logic           busy,
    output logic           res_valid,
    output logic           res_bit,
    output logic           done
);
    localparam int NN     = N * N;
    localparam int SW     = $clog2(N);
    localparam int IW     = $clog2(NN);
    localparam int PASSES = pass_count(N);

    typedef struct packed {
        logic [NN-1:0] acc;
        logic [NN-1:0] h;
        logic [NN-1:0] v;
    } mesh_t;

    mesh_t mesh_d, mesh_q;

    logic          load_en;
    logic          run_en;
    logic [SW-1:0] step;
    logic [IW-1:0] dump_idx;

    logic [NN-1:0] forced;
    logic [NN-1:0] load_h, load_v;
    logic [NN-1:0] cell_acc_d, cell_h_out, cell_v_out;
    logic [NN-1:0] h_shift, v_shift;
    logic [N-1:0]  row_hit, col_hit;
    logic [NN-1:0] acc_q;

    reach_seq #(.N(N), .PASSES(PASSES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load_en   (load_en),
        .run_en    (run_en),
        .step      (step),
        .dump_idx  (dump_idx),
        .res_valid (res_valid),
        .done      (done),
        .busy      (busy)
    );

    // Home tokens: during cycle t of a pass, row t and column t are home.
    for (genvar r = 0; r < N; r++) begin : g_tok
        assign row_hit[r] = run_en && (step == SW'(r));
        assign col_hit[r] = run_en && (step == SW'(r));
    end

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            localparam int C  = i * N + j;
            localparam int K  = (i + j) % N;
            localparam int CR = i * N + ((j + 1) % N);
            localparam int CD = ((i + 1) % N) * N + j;

            assign forced[C] = adj_in[C] | (i == j);
            assign load_h[C] = forced[i * N + K];
            assign load_v[C] = forced[K * N + j];

            reach_cell u_cell (
                .acc_q    (mesh_q.acc[C]),
                .h_in     (mesh_q.h[C]),
                .v_in     (mesh_q.v[C]),
                .row_home (row_hit[i]),
                .col_home (col_hit[j]),
                .acc_d    (cell_acc_d[C]),
                .h_out    (cell_h_out[C]),
                .v_out    (cell_v_out[C])
            );

            assign h_shift[CR] = cell_h_out[C];
            assign v_shift[CD] = cell_v_out[C];
        end
    end

    always_comb begin
        mesh_d = mesh_q;
        if (load_en) begin
            mesh_d.acc = '0;
            mesh_d.h   = load_h;
            mesh_d.v   = load_v;
        end else if (run_en) begin
            mesh_d.acc = cell_acc_d;
            mesh_d.h   = h_shift;
            mesh_d.v   = v_shift;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mesh_q <= '0;
        end else begin
            mesh_q <= mesh_d;
        end
    end

    assign acc_q   = mesh_q.acc;
    assign res_bit = acc_q[dump_idx];
endmodule

// File: rtl/reach_mesh_chk.sv
module reach_mesh_chk #(
    parameter int N = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   busy,
    input logic                   res_valid,
    input logic                   res_bit,
    input logic                   done,
    input logic                   run_en,
    input logic [$clog2(N*N)-1:0] dump_idx,
    input logic [N*N-1:0]         acc_q
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!res_valid && !done));

    assert_acc_grow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && $past(run_en)) |-> ((acc_q & $past(acc_q)) == $past(acc_q)));

    assert_diag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && ((int'(dump_idx) % (N + 1)) == 0)) |-> res_bit);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> res_valid);

    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind reach_mesh reach_mesh_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .res_valid (res_valid),
    .res_bit   (res_bit),
    .done      (done),
    .run_en    (run_en),
    .dump_idx  (dump_idx),
    .acc_q     (acc_q)
);

// File: tb/reach_mesh_bench.sv
`timescale 1ns/1ps
module reach_mesh_bench;
    localparam int N  = 6;
    localparam int NN = N * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NN-1:0] adj_in = '0;
    logic          busy, res_valid, res_bit, done;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    reach_mesh #(.N(N)) u_reach_mesh (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .adj_in    (adj_in),
        .busy      (busy),
        .res_valid (res_valid),
        .res_bit   (res_bit),
        .done      (done)
    );

    function automatic int exp_latency();
        int m;
        m = $clog2(N - 1);
        return ((m == 0) ? 1 : 2 * m - 1) * N;
    endfunction

    function automatic logic [NN-1:0] closure(input logic [NN-1:0] a);
        logic [NN-1:0] r;
        r = a;
        for (int i = 0; i < N; i++) r[i * N + i] = 1'b1;
        for (int k = 0; k < N; k++)
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    if (r[i * N + k] && r[k * N + j]) r[i * N + j] = 1'b1;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [NN-1:0] act, input logic [NN-1:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input logic [NN-1:0] a, input string name, input bit disturb);
        logic [NN-1:0] got;
        logic [NN-1:0] want;
        int lat;
        int done_hits;
        bit done_wrong;
        bit valid_gap;
        want = closure(a);
        got = '0;
        @(negedge clk);
        adj_in = a;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!res_valid && lat < 1000) begin
            if (disturb && lat == 3) begin
                adj_in = ~a;
                start  = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check(lat == exp_latency(), "R5", {name, " latency"},
              NN'(lat), NN'(exp_latency()));
        done_hits = 0;
        done_wrong = 1'b0;
        valid_gap = 1'b0;
        for (int c = 0; c < NN; c++) begin
            if (!res_valid) valid_gap = 1'b1;
            got[c] = res_bit;
            if (done) done_hits++;
            if (done != (c == NN - 1)) done_wrong = 1'b1;
            if (disturb && c == 2) begin
                adj_in = '1;
                start  = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(got == want, disturb ? "R4" : "R2", {name, " closure (R8 growth)"}, got, want);
        check(!done_wrong && done_hits == 1 && !valid_gap, "R6", {name, " done/valid framing"},
              NN'(done_hits), NN'(1));
        check(!busy && !res_valid, "R7", {name, " idle after last bit"},
              NN'({busy, res_valid}), NN'(0));
    endtask

    initial begin
        logic [NN-1:0] m;
        logic [NN-1:0] ident;
        int seed_sink;
        seed_sink = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        check(!busy && !res_valid && !done, "R1", "reset state",
              NN'({busy, res_valid, done}), NN'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !res_valid && !done, "R1", "first cycle after reset",
              NN'({busy, res_valid, done}), NN'(0));

        ident = '0;
        for (int i = 0; i < N; i++) ident[i * N + i] = 1'b1;
        run_case('0, "empty graph", 1'b0);
        check(closure('0) == ident, "R3", "identity model", closure('0), ident);

        m = '0;
        for (int i = 0; i < N; i++) m[i * N + ((i + 1) % N)] = 1'b1;
        run_case(m, "long cycle", 1'b0);

        m = '0;
        for (int i = 0; i + 1 < N; i++) m[(i + 1) * N + i] = 1'b1;
        run_case(m, "reverse chain", 1'b0);

        run_case('1, "complete graph", 1'b0);

        m = '0;
        for (int i = 0; i < N; i++) m[((i + 2) % N) * N + i] = 1'b1;
        run_case(m, "stride cycle busy start", 1'b1);

        for (int t = 0; t < 20; t++) begin
            int dens;
            dens = (t % 3 == 0) ? 6 : ((t % 3 == 1) ? 12 : 25);
            m = '0;
            for (int b = 0; b < NN; b++) m[b] = (($urandom % 100) < dens);
            run_case(m, "random", (t % 5 == 4));
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL R6 watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule